// File: doc/BRIEF.md
# Condition-Field Masked Lookup Logic Unit

This unit keeps a 32-bit condition register built from eight 4-bit fields and runs two field-wide logic instructions against it. Each instruction names a target field and two source fields, and computes all four bit lanes of the target at once. The ternary form looks up each lane's result in an 8-entry table carried inside the instruction word. The binary form takes its 4-entry table from the contents of a third condition field, so software can change the function at run time.

A 4-bit write mask in the instruction chooses which lanes of the target field take the new value. Lanes outside the mask keep their old value, and every other field is left alone. An instruction with an empty mask is not treated as a no-op: it raises an illegal-instruction trap. A word that decodes to neither form raises a separate unsupported flag. A direct load port overwrites the whole register. Each instruction reports exactly one outcome, one cycle after it is presented.

Top module: `cr_lut_unit`

## Requirements
- R1: While `rst_n` is low, `cr_value` is zero and `done`, `illegal_trap` and `unsupported` are low.
- R2: When `load_en` is high at a clock edge, `cr_value` shows `load_data` after that edge.
- R3: Field n (0..7) occupies `cr_value[31-4n:28-4n]`. Lane i of a field is the bit at position 3-i of that slice, so lane 0 is the most significant bit. Word bits are numbered here in the `instr_word[31:0]` convention. The target index is in [25:23], source A is in [20:18] and source B is in [15:13]. A word is recognised when [31:26] equals 22 and [5:1] equals 8 (ternary) or 9 (binary).
- R4: Ternary form: the 8-bit table is {[12:6], [0]}, with table bit j counted from the least significant end. Lane i of the target takes table bit j, where j = 4·target[i] + 2·A[i] + B[i].
- R5: Binary form: lane i of the target takes lane j of field B, where j = 2·target[i] + A[i]. Bits [12:6] and [0] have no effect.
- R6: The mask is {[22:21], [17:16]}, and mask bit 3-i enables lane i. A disabled lane keeps its old value, and no field other than the target changes.
- R7: All three source fields are read from the register value before the update, including when the target equals A, equals B, or equals both.
- R8: A recognised word with a zero mask sets `illegal_trap` for one cycle, does not set `done`, and leaves `cr_value` unchanged.
- R9: An unrecognised word sets `unsupported` for one cycle and leaves `cr_value` unchanged.
- R10: A valid instruction at a clock edge produces exactly one of `done`, `illegal_trap` or `unsupported` in the following cycle, and the updated register appears in that same cycle. With no valid instruction, all three flags stay low.
- R11: When a load and an instruction arrive at the same edge, the register takes `load_data`, and the instruction's outcome flag is still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr_word | input | 32 | Instruction word |
| load_en | input | 1 | Direct load of the whole register |
| load_data | input | 32 | Value for the direct load |
| cr_value | output | 32 | Condition register contents |
| done | output | 1 | Instruction committed (one-cycle pulse) |
| illegal_trap | output | 1 | Recognised instruction with an empty mask |
| unsupported | output | 1 | Unrecognised instruction word |

## Verification
The direct load and an instruction's write can target the register in the same cycle. The bench raises `load_en` and `instr_valid` on the same clock edge, using both legal and zero-mask words. It then expects the loaded value in the register and the instruction's outcome flag still reported. A second collision occurs inside a single instruction, when the target field is also a source. The bench sweeps every target with source A, source B, or both aliased to it, and compares the result against a model that reads the pre-update register.

// File: rtl/cr_lut_pkg.sv
package cr_lut_pkg;
    localparam int FIELD_W    = 4;
    localparam int NUM_FIELDS = 8;
    localparam int CR_W       = FIELD_W * NUM_FIELDS;
    localparam int IDX_W      = $clog2(NUM_FIELDS);
    localparam int TBL_W      = 8;

    localparam logic [5:0] PRIMARY_OP = 6'd22;
    localparam logic [4:0] XO_TERN    = 5'd8;
    localparam logic [4:0] XO_BIN     = 5'd9;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_TERN = 2'd1,
        OP_BIN  = 2'd2
    } op_kind_e;

    typedef struct packed {
        logic [CR_W-1:0] cr;
        logic [CR_W-1:0] wmask;
        logic            done;
        logic            trap;
        logic            unsup;
    } unit_state_t;
endpackage

// File: rtl/cr_lut_decode.sv
module cr_lut_decode
    import cr_lut_pkg::*;
(
    input  logic [31:0]            instr,
    output op_kind_e               kind,
    output logic [IDX_W-1:0]       tgt_idx,
    output logic [IDX_W-1:0]       srca_idx,
    output logic [IDX_W-1:0]       srcb_idx,
    output logic [FIELD_W-1:0]     lane_mask,
    output logic [TBL_W-1:0]       imm_tbl
);
    logic [5:0] primary;
    logic [4:0] ext_op;

    always_comb begin
        primary   = instr[31:26];
        ext_op    = instr[5:1];
        tgt_idx   = instr[25:23];
        srca_idx  = instr[20:18];
        srcb_idx  = instr[15:13];
        // mask is split in two halves around the source-A index
        lane_mask = {instr[22:21], instr[17:16]};
        // table tail sits in the very last word bit
        imm_tbl   = {instr[12:6], instr[0]};
        kind      = OP_NONE;
        if (primary == PRIMARY_OP) begin
            if (ext_op == XO_TERN)     kind = OP_TERN;
            else if (ext_op == XO_BIN) kind = OP_BIN;
        end
    end

    always_comb begin
        assert (!(kind == OP_TERN && ext_op != XO_TERN))
            else $error("AST_DECODE_TERN failed"); // R3
    end
endmodule

// File: rtl/cr_lut_field_pick.sv
module cr_lut_field_pick #(
    parameter int FW = 4,
    parameter int NF = 8,
    localparam int CRW = FW * NF,
    localparam int IW  = $clog2(NF)
) (
    input  logic [CRW-1:0] cr,
    input  logic [IW-1:0]  idx,
    output logic [FW-1:0]  fld
);
    // field 0 sits at the most significant end
    always_comb fld = cr[(NF - 1 - int'(idx)) * FW +: FW];
endmodule

// File: rtl/cr_lut_lanes.sv
module cr_lut_lanes
    import cr_lut_pkg::*;
(
    input  op_kind_e           kind,
    input  logic [FIELD_W-1:0] fld_t,
    input  logic [FIELD_W-1:0] fld_a,
    input  logic [FIELD_W-1:0] fld_b,
    input  logic [TBL_W-1:0]   imm_tbl,
    output logic [FIELD_W-1:0] res
);
    for (genvar k = 0; k < FIELD_W; k++) begin : g_lane
        logic [2:0] tern_sel;
        logic [1:0] bin_sel;
        always_comb begin
            tern_sel = {fld_t[k], fld_a[k], fld_b[k]};
            bin_sel  = {fld_t[k], fld_a[k]};
            // binary table entry j is lane j of field B (lane 0 = MSB)
            res[k]   = (kind == OP_TERN) ? imm_tbl[tern_sel]
                                         : fld_b[2'd3 - bin_sel];
        end
    end
endmodule

// File: rtl/cr_lut_unit.sv
module cr_lut_unit
    import cr_lut_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        instr_valid,
    input  logic [31:0] instr_word,
    input  logic        load_en,
    input  logic [31:0] load_data,
    output logic [31:0] cr_value,
    output logic        done,
    output logic        illegal_trap,
    output logic        unsupported
);
    unit_state_t          st_d, st_q;
    op_kind_e             kind;
    logic [IDX_W-1:0]     tgt_idx, srca_idx, srcb_idx;
    logic [FIELD_W-1:0]   lane_mask;
    logic [TBL_W-1:0]     imm_tbl;
    logic [FIELD_W-1:0]   fld_t, fld_a, fld_b, lane_res;

    cr_lut_decode u_dec (
        .instr     (instr_word),
        .kind      (kind),
        .tgt_idx   (tgt_idx),
        .srca_idx  (srca_idx),
        .srcb_idx  (srcb_idx),
        .lane_mask (lane_mask),
        .imm_tbl   (imm_tbl)
    );

    cr_lut_field_pick #(.FW(FIELD_W), .NF(NUM_FIELDS)) u_pick_t (
        .cr(st_q.cr), .idx(tgt_idx), .fld(fld_t));
    cr_lut_field_pick #(.FW(FIELD_W), .NF(NUM_FIELDS)) u_pick_a (
        .cr(st_q.cr), .idx(srca_idx), .fld(fld_a));
    cr_lut_field_pick #(.FW(FIELD_W), .NF(NUM_FIELDS)) u_pick_b (
        .cr(st_q.cr), .idx(srcb_idx), .fld(fld_b));

    cr_lut_lanes u_lanes (
        .kind    (kind),
        .fld_t   (fld_t),
        .fld_a   (fld_a),
        .fld_b   (fld_b),
        .imm_tbl (imm_tbl),
        .res     (lane_res)
    );

    always_comb begin
        logic [CR_W-1:0] wm;
        wm          = '0;
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.trap   = 1'b0;
        st_d.unsup  = 1'b0;
        st_d.wmask  = '0;
        for (int n = 0; n < NUM_FIELDS; n++) begin
            if (n == int'(tgt_idx)) wm[(NUM_FIELDS - 1 - n) * FIELD_W +: FIELD_W] = lane_mask;
        end
        if (instr_valid) begin
            if (kind == OP_NONE) begin
                st_d.unsup = 1'b1;
            end else if (lane_mask == '0) begin
                st_d.trap = 1'b1;
            end else begin
                st_d.done  = 1'b1;
                st_d.wmask = wm;
                st_d.cr    = (st_q.cr & ~wm) | ({NUM_FIELDS{lane_res}} & wm);
            end
        end
        if (load_en) st_d.cr = load_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cr_value     = st_q.cr;
    assign done         = st_q.done;
    assign illegal_trap = st_q.trap;
    assign unsupported  = st_q.unsup;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, illegal_trap, unsupported})); // R10
    AST_VALID_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> $countones({done, illegal_trap, unsupported}) == 1); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !(done || illegal_trap || unsupported)); // R10
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> cr_value == $past(load_data)); // R11
    AST_TRAP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_trap && !$past(load_en)) |-> cr_value == $past(cr_value)); // R8
    AST_UNSUP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (unsupported && !$past(load_en)) |-> cr_value == $past(cr_value)); // R9
    AST_OUTSIDE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(load_en)) |->
        (cr_value & ~st_q.wmask) == ($past(cr_value) & ~st_q.wmask)); // R6
endmodule

// File: tb/cr_lut_unit_tb_top.sv
`timescale 1ns/1ps
module cr_lut_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        load_en = 1'b0;
    logic [31:0] load_data = '0;
    logic [31:0] cr_value;
    logic        done, illegal_trap, unsupported;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cr_lut_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .load_en(load_en), .load_data(load_data), .cr_value(cr_value),
        .done(done), .illegal_trap(illegal_trap), .unsupported(unsupported)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // form: 0 ternary, 1 binary; junk fills unused table bits for binary
    function automatic logic [31:0] mk(input bit form, input int t, input int a, input int b,
                                       input logic [3:0] m, input logic [7:0] tbl);
        logic [31:0] w;
        w        = '0;
        w[31:26] = 6'd22;
        w[25:23] = 3'(t);
        w[22:21] = m[3:2];
        w[20:18] = 3'(a);
        w[17:16] = m[1:0];
        w[15:13] = 3'(b);
        w[12:6]  = tbl[7:1];
        w[5:1]   = form ? 5'd9 : 5'd8;
        w[0]     = tbl[0];
        return w;
    endfunction

    function automatic logic [31:0] model(input logic [31:0] cr, input bit form, input int t,
                                          input int a, input int b, input logic [3:0] m,
                                          input logic [7:0] tbl);
        logic [31:0] r;
        r = cr;
        for (int i = 0; i < 4; i++) begin
            int j;
            int pt;
            pt = 31 - (4 * t + i);
            if (form == 0) begin
                j = 4 * cr[pt] + 2 * cr[31 - 4 * a - i] + cr[31 - 4 * b - i];
                if (m[3 - i]) r[pt] = tbl[j];
            end else begin
                j = 2 * cr[pt] + cr[31 - 4 * a - i];
                if (m[3 - i]) r[pt] = cr[31 - 4 * b - j];
            end
        end
        return r;
    endfunction

    task automatic do_load(input logic [31:0] v);
        @(negedge clk);
        load_en = 1'b1; load_data = v;
        @(posedge clk);
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic run_instr(input string req, input logic [31:0] w, input logic [31:0] exp_cr,
                             input logic [2:0] exp_flags);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = w;
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        check(req, cr_value, exp_cr);
        check({req, " R10 flags"}, {29'd0, done, illegal_trap, unsupported}, {29'd0, exp_flags});
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed_cr;
        void'($urandom(32'd7));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        check("R1 reset cr", cr_value, 32'h0);
        check("R1 reset flags", {29'd0, done, illegal_trap, unsupported}, 32'h0);
        rst_n = 1'b1;

        // R2
        do_load(32'hA5C3_0F96);
        check("R2 load", cr_value, 32'hA5C3_0F96);
        check("R10 idle quiet", {29'd0, done, illegal_trap, unsupported}, 32'h0);

        // R3 R4 R5 R6 R8: every form, target and mask value
        for (int f = 0; f < 2; f++) begin
            for (int t = 0; t < 8; t++) begin
                for (int m = 0; m < 16; m++) begin
                    int a;
                    int b;
                    logic [7:0] tbl;
                    logic [31:0] w;
                    seed_cr = $urandom;
                    a   = $urandom_range(0, 7);
                    b   = $urandom_range(0, 7);
                    tbl = 8'($urandom);
                    do_load(seed_cr);
                    w = mk(f[0], t, a, b, 4'(m), tbl);
                    if (m == 0)
                        run_instr("R8 zero mask", w, seed_cr, 3'b010);
                    else if (f == 0)
                        run_instr("R4 R6 ternary", w, model(seed_cr, 1'b0, t, a, b, 4'(m), tbl), 3'b100);
                    else
                        run_instr("R5 R6 binary", w, model(seed_cr, 1'b1, t, a, b, 4'(m), tbl), 3'b100);
                end
            end
        end

        // R7: aliasing of target with sources
        for (int f = 0; f < 2; f++) begin
            for (int t = 0; t < 8; t++) begin
                for (int k = 0; k < 3; k++) begin
                    int a;
                    int b;
                    logic [7:0] tbl;
                    a   = (k == 1) ? (t + 3) % 8 : t;
                    b   = (k == 0) ? (t + 5) % 8 : t;
                    tbl = 8'($urandom);
                    seed_cr = $urandom;
                    do_load(seed_cr);
                    run_instr("R7 alias", mk(f[0], t, a, b, 4'hF, tbl),
                              model(seed_cr, f[0], t, a, b, 4'hF, tbl), 3'b100);
                end
            end
        end

        // R4 known function: majority in field 2 from fields 0,1,2 -> table 0xE8
        do_load(32'hC_A_6_00000);
        run_instr("R4 majority", mk(1'b0, 2, 0, 1, 4'hF, 8'hE8), 32'hC_A_E_00000, 3'b100);

        // R5 binary table bits ignored: two words differing only in them agree
        seed_cr = 32'h1234_5678;
        do_load(seed_cr);
        run_instr("R5 table bits ignored", mk(1'b1, 4, 5, 6, 4'hF, 8'h00),
                  model(seed_cr, 1'b1, 4, 5, 6, 4'hF, 8'h00), 3'b100);
        do_load(seed_cr);
        run_instr("R5 table bits ignored", mk(1'b1, 4, 5, 6, 4'hF, 8'hFF),
                  model(seed_cr, 1'b1, 4, 5, 6, 4'hF, 8'h00), 3'b100);

        // R9: wrong primary and wrong extended opcode
        do_load(32'hDEAD_BEEF);
        run_instr("R9 bad primary", mk(1'b0, 1, 2, 3, 4'hF, 8'h96) ^ 32'h0400_0000, 32'hDEAD_BEEF, 3'b001);
        run_instr("R9 bad xo", mk(1'b0, 1, 2, 3, 4'hF, 8'h96) ^ 32'h0000_0020, 32'hDEAD_BEEF, 3'b001);

        // R10: back-to-back then idle
        @(negedge clk);
        check("R10 idle after instr", {29'd0, done, illegal_trap, unsupported}, 32'h0);

        // R11: load and instruction together
        @(negedge clk);
        load_en = 1'b1; load_data = 32'h0BAD_F00D;
        instr_valid = 1'b1; instr_word = mk(1'b0, 0, 1, 2, 4'hF, 8'hFF);
        @(posedge clk);
        @(negedge clk);
        load_en = 1'b0; instr_valid = 1'b0;
        check("R11 load wins", cr_value, 32'h0BAD_F00D);
        check("R11 done still reported", {31'd0, done}, 32'h1);
        @(negedge clk);
        load_en = 1'b1; load_data = 32'h7777_0001;
        instr_valid = 1'b1; instr_word = mk(1'b1, 3, 1, 2, 4'h0, 8'h00);
        @(posedge clk);
        @(negedge clk);
        load_en = 1'b0; instr_valid = 1'b0;
        check("R11 load with trap", cr_value, 32'h7777_0001);
        check("R11 trap still reported", {31'd0, illegal_trap}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule